// File: doc/BRIEF.md
# Horizontal Sub-Pixel Luma Interpolator

This block shifts a raster stream of 8-bit luminance samples to the left by a fixed fraction of a pixel. The fraction (one quarter, one half or three quarters) is chosen per instance by a parameter. The block keeps the eight most recent accepted samples in a window. It multiplies them by a constant set of eight signed taps and adds the products. It then rounds, divides by 64 and saturates the result to an unsigned byte.

Samples enter on a plain valid strobe with no ready signal. The stream has no back-pressure: the sink must take every result on the cycle it is flagged. When the strobe is low, the line ends and the next valid sample starts a fresh one. A fresh line produces nothing until eight samples of that line have been taken in. The design uses one clock and an active-low asynchronous reset. A system that needs several fractions instantiates the block once for each.

Top module: `subpel_hfilter`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_pixel` is 0 until the first result is produced.
- R2: A sample on `in_pixel` is taken into the window only on a rising clock edge where `in_valid` is 1. Samples presented with `in_valid` at 0 affect no later result.
- R3: Any cycle with `in_valid` at 0 ends the current line. No result is flagged until eight consecutive valid samples of the new line have been accepted.
- R4: `out_valid` is 1 on the edge that follows each accepted sample which leaves the window holding eight samples of the current line. It is 0 on every other cycle.
- R5: Windows are indexed oldest sample first, w[0] oldest to w[7] newest. With `FRAC`=2 the taps are -1,4,-11,40,40,-11,4,-1. With `FRAC`=1 they are -1,4,-10,58,17,-5,1,0. With `FRAC`=3 they are the `FRAC`=1 set reversed. The sum is S = Σ tap[i]·w[i].
- R6: The result is floor((S + 32) / 64), computed with signed arithmetic.
- R7: A result below 0 is output as 0, and one above 255 is output as 255.
- R8: On cycles where `out_valid` is 0, `out_pixel` holds the last flagged result.
- R9: An unbroken run of valid input yields one flagged result per clock after the window has filled. Nothing stalls, because the interface has no back-pressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe; low ends the line |
| in_pixel | input | 8 | Unsigned input luma sample |
| out_valid | output | 1 | Result strobe |
| out_pixel | output | 8 | Filtered, saturated luma sample |

## Verification
A sample driven before rising edge k enters the window at edge k. Its result appears on the outputs at edge k+1. The bench therefore carries each expectation through a two-stage queue. It compares outputs on the falling edge two drive slots after the stimulus, and every cycle it compares both the strobe and the held data. In the bound checker, the rule that a filled window brings a result one edge later is expressed as a two-step implication. The rule that a result must follow eight accepted samples uses a run counter kept in the checker.

// File: rtl/subpel_pkg.sv
package subpel_pkg;

  localparam int NTAPS = 8;

  localparam logic signed [7:0] HALF_TAPS [NTAPS] = '{
    -8'sd1, 8'sd4, -8'sd11, 8'sd40, 8'sd40, -8'sd11, 8'sd4, -8'sd1
  };

  localparam logic signed [7:0] QTR_TAPS [NTAPS] = '{
    -8'sd1, 8'sd4, -8'sd10, 8'sd58, 8'sd17, -8'sd5, 8'sd1, 8'sd0
  };

  // frac: 1 quarter, 2 half, 3 three-quarter (quarter set mirrored)
  function automatic logic signed [7:0] tap_coef(input int frac, input int idx);
    logic signed [7:0] c;
    case (frac)
      1:       c = QTR_TAPS[idx];
      3:       c = QTR_TAPS[NTAPS-1-idx];
      default: c = HALF_TAPS[idx];
    endcase
    return c;
  endfunction

endpackage

// File: rtl/subpel_window.sv
module subpel_window #(
  parameter int PIX_W = 8,
  parameter int TAPS  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [PIX_W-1:0]            in_pixel,
  output logic [TAPS-1:0][PIX_W-1:0]  win,
  output logic                        fire
);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(TAPS);
  localparam logic [CNT_W-1:0] ALMOST  = CNT_W'(TAPS - 1);

  logic [CNT_W-1:0] fill;

  // win[TAPS-1] is newest, win[0] oldest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win  <= '0;
      fill <= '0;
      fire <= 1'b0;
    end else if (in_valid) begin
      win  <= {in_pixel, win[TAPS-1:1]};
      fill <= (fill == FULL) ? FULL : fill + 1'b1;
      fire <= (fill >= ALMOST);
    end else begin
      fill <= '0;
      fire <= 1'b0;
    end
  end

endmodule

// File: rtl/subpel_mac.sv
module subpel_mac #(
  parameter int PIX_W  = 8,
  parameter int TAPS   = 8,
  parameter int PROD_W = 16,
  parameter int SUM_W  = 19,
  parameter int FRAC   = 2
) (
  input  logic [TAPS-1:0][PIX_W-1:0] win,
  output logic signed [SUM_W-1:0]    sum
);
  logic signed [PROD_W-1:0] prod [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam logic signed [PROD_W-1:0] CF = PROD_W'(subpel_pkg::tap_coef(FRAC, i));
    logic signed [PROD_W-1:0] px;
    assign px      = $signed({{(PROD_W-PIX_W){1'b0}}, win[i]});
    assign prod[i] = px * CF;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < TAPS; i++) begin
      sum = sum + SUM_W'(prod[i]);
    end
  end

endmodule

// File: rtl/subpel_round_clip.sv
module subpel_round_clip #(
  parameter int PIX_W = 8,
  parameter int SUM_W = 19,
  parameter int SHIFT = 6
) (
  input  logic signed [SUM_W-1:0] sum,
  output logic [PIX_W-1:0]        pix
);
  localparam logic signed [SUM_W-1:0] RND  = SUM_W'(1 << (SHIFT - 1));
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  logic signed [SUM_W-1:0] biased;
  logic signed [SUM_W-1:0] scaled;

  assign biased = sum + RND;
  assign scaled = biased >>> SHIFT;

  always_comb begin
    if (scaled < 0)         pix = '0;
    else if (scaled > MAXV) pix = '1;
    else                    pix = scaled[PIX_W-1:0];
  end

endmodule

// File: rtl/subpel_hfilter.sv
module subpel_hfilter #(
  parameter int FRAC   = 2,
  parameter int PIX_W  = 8,
  parameter int PROD_W = 16,
  parameter int SHIFT  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pixel
);
  localparam int TAPS  = subpel_pkg::NTAPS;
  localparam int SUM_W = PROD_W + $clog2(TAPS);

  logic [TAPS-1:0][PIX_W-1:0] win;
  logic                       fire;
  logic signed [SUM_W-1:0]    sum;
  logic [PIX_W-1:0]           pix;

  subpel_window #(.PIX_W(PIX_W), .TAPS(TAPS)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_pixel (in_pixel),
    .win      (win),
    .fire     (fire)
  );

  subpel_mac #(
    .PIX_W(PIX_W), .TAPS(TAPS), .PROD_W(PROD_W), .SUM_W(SUM_W), .FRAC(FRAC)
  ) u_mac (
    .win (win),
    .sum (sum)
  );

  subpel_round_clip #(.PIX_W(PIX_W), .SUM_W(SUM_W), .SHIFT(SHIFT)) u_norm (
    .sum (sum),
    .pix (pix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_pixel <= pix;
    end
  end

endmodule

// File: rtl/subpel_hfilter_chk.sv
module subpel_hfilter_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pixel
);
  logic [3:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run <= '0;
    else if (!in_valid) run <= '0;
    else if (run != 4'd15) run <= run + 4'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!out_valid);
    end
  end

  // R3: a result needs eight consecutive accepted samples
  p_full_before_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(run) >= 4'd8));

  // R4: filling sample produces a flagged result one edge later
  p_fill_gives_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && run >= 4'd7) |=> ##1 out_valid);

  // R4: no result unless the preceding cycle accepted a sample
  p_out_needs_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R8: data held while no result is flagged
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_pixel));

endmodule

bind subpel_hfilter subpel_hfilter_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_pixel (out_pixel)
);

// File: tb/test_subpel_hfilter.sv
module test_subpel_hfilter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_pixel = '0;
  logic       ov [3];
  logic [7:0] op [3];

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  // lane 0 quarter, lane 1 half, lane 2 three-quarter
  subpel_hfilter #(.FRAC(1)) i_quarter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel),
    .out_valid(ov[0]), .out_pixel(op[0]));
  subpel_hfilter #(.FRAC(2)) i_subpel_hfilter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel),
    .out_valid(ov[1]), .out_pixel(op[1]));
  subpel_hfilter #(.FRAC(3)) i_threeq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel),
    .out_valid(ov[2]), .out_pixel(op[2]));

  int coef [3][8];
  int hist [8];
  int cnt = 0;
  logic ev1 [3], ev2 [3];
  int   ed1 [3], ed2 [3], last [3];

  function automatic int model(int lane);
    int s = 0;
    int r;
    for (int i = 0; i < 8; i++) s += coef[lane][i] * hist[i];
    r = (s + 32) >>> 6;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic check(string t, int lane, int act, int exp_v);
    tests++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s lane %0d: actual %0d expected %0d", t, lane, act, exp_v);
    end
  endtask

  task automatic step(logic v, logic [7:0] p);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check((tag == "R1") ? "R1" : "R4", k, int'(ov[k]), int'(ev2[k]));
      if (ev2[k]) begin
        check(tag, k, int'(op[k]), ed2[k]);
        last[k] = ed2[k];
      end else begin
        check("R8", k, int'(op[k]), last[k]);
      end
      ev2[k] = ev1[k];
      ed2[k] = ed1[k];
    end
    if (v) begin
      for (int i = 0; i < 7; i++) hist[i] = hist[i+1];
      hist[7] = int'(p);
      if (cnt < 8) cnt++;
      for (int k = 0; k < 3; k++) begin
        ev1[k] = (cnt == 8);
        ed1[k] = model(k);
      end
    end else begin
      cnt = 0;
      for (int k = 0; k < 3; k++) ev1[k] = 1'b0;
    end
    in_valid = v;
    in_pixel = p;
  endtask

  task automatic feed8(int a0, int a1, int a2, int a3, int a4, int a5, int a6, int a7);
    step(1'b1, 8'(a0)); step(1'b1, 8'(a1)); step(1'b1, 8'(a2)); step(1'b1, 8'(a3));
    step(1'b1, 8'(a4)); step(1'b1, 8'(a5)); step(1'b1, 8'(a6)); step(1'b1, 8'(a7));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    coef[1] = '{-1, 4, -11, 40, 40, -11, 4, -1};
    coef[0] = '{-1, 4, -10, 58, 17, -5, 1, 0};
    for (int i = 0; i < 8; i++) coef[2][i] = coef[0][7-i];
    for (int i = 0; i < 8; i++) hist[i] = 0;
    for (int k = 0; k < 3; k++) begin
      ev1[k] = 0; ev2[k] = 0; ed1[k] = 0; ed2[k] = 0; last[k] = 0;
    end

    // R1: reset state, also with input toggling during reset
    tag = "R1";
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_pixel = 8'd99;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check("R1", k, int'(ov[k]), 0);
      check("R1", k, int'(op[k]), 0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 8'd0);

    // R9/R5: continuous ramp, one result per clock once filled
    tag = "R9";
    for (int i = 0; i < 256; i++) step(1'b1, 8'(i));
    step(1'b0, 8'd0);

    // R2: junk data with valid low must not reach any result
    tag = "R2";
    for (int i = 0; i < 5; i++) step(1'b0, 8'd255);
    for (int i = 0; i < 12; i++) step(1'b1, 8'd0);
    step(1'b0, 8'd200);

    // R5: impulse walks past every tap position
    tag = "R5";
    feed8(0, 0, 0, 0, 0, 0, 0, 0);
    step(1'b1, 8'd255);
    for (int i = 0; i < 9; i++) step(1'b1, 8'd0);
    step(1'b0, 8'd0);

    // R3: line broken after seven samples, then refilled
    tag = "R3";
    for (int i = 0; i < 7; i++) step(1'b1, 8'(30 + i));
    step(1'b0, 8'd0);
    for (int i = 0; i < 7; i++) step(1'b1, 8'(60 + i));
    step(1'b0, 8'd0);
    step(1'b0, 8'd0);
    for (int i = 0; i < 10; i++) step(1'b1, 8'(90 + 7 * i));
    step(1'b0, 8'd0);

    // R7: saturation high (half/quarter) and low (quarter)
    tag = "R7";
    feed8(0, 255, 0, 255, 255, 0, 255, 0);
    step(1'b0, 8'd0);
    feed8(0, 255, 0, 255, 255, 0, 255, 255);
    step(1'b0, 8'd0);
    feed8(255, 0, 255, 0, 0, 255, 0, 0);
    step(1'b0, 8'd0);
    feed8(0, 0, 255, 0, 0, 255, 0, 255);
    step(1'b0, 8'd0);
    for (int i = 0; i < 16; i++) step(1'b1, (i % 2) ? 8'd255 : 8'd0);
    for (int i = 0; i < 16; i++) step(1'b1, 8'd255);
    step(1'b0, 8'd0);

    // R6: pseudo-random data with random gaps exercises rounding
    tag = "R6";
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step((lfsr[3:0] != 4'd0), lfsr[15:8]);
    end
    for (int i = 0; i < 4; i++) step(1'b0, 8'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule